// File: doc/BRIEF.md
# SDRAM Refresh and Initialization Sequencer

This block generates the housekeeping commands that an SDRAM controller has to interleave with normal reads and writes. A period timer counts clock cycles. Each time it expires, a small saturating counter of owed refreshes is incremented. The sequencer repays that debt with bursts that always start with a precharge of every bank and continue with auto-refresh commands until nothing is owed. A separate one-shot request runs the power-up sequence. That sequence is a precharge of all banks, then a fixed number of auto-refreshes, then a mode-register load. The request clears itself once the mode register has been written.

The block talks to the access arbiter through two signals. It reads `path_idle`, which reports that no access is in flight. It drives `maint_req`, which tells the arbiter to start no new access. When the debt is small, a burst is requested only while the path is already idle, so ordinary traffic is not held up. When the counter has saturated, the request goes up at once and the burst runs as soon as the current access has drained. Every precharge-all also pulses `page_inval`, so that the controller drops its open-row record. Command spacing follows two programmable gap fields.

Top module: `sdram_maint_seq`

## Requirements
- R1: While `rst` is high, the command outputs, `page_inval`, `init_busy`, `init_done`, `maint_req` and `maint_urgent` are all low, provided `refresh_en` is low.
- R2: While `refresh_en` is low and no initialization is pending, no command is issued and `maint_req` and `maint_urgent` stay low.
- R3: The backlog counter resets to its maximum of 3. The first time refresh is enabled on an idle path, the block issues one precharge-all followed by exactly 3 auto-refreshes and no mode-register load.
- R4: At most one of `cmd_dcab`, `cmd_refr`, `cmd_mrs` is high in any cycle, and `page_inval` is high exactly in the cycles where `cmd_dcab` is high.
- R5: With refresh enabled and the path idle, the timer expires once every `period` cycles (a value of 0 counts as 1). Each expiry produces one precharge-all followed by one auto-refresh, so successive periodic auto-refreshes are exactly `period` cycles apart.
- R6: The command after a precharge-all comes exactly `trp_gap`+1 cycles after it. The command after an auto-refresh comes exactly `trc_gap`+1 cycles after it. A gap field of 0 gives commands in consecutive cycles.
- R7: While the backlog is 1 or 2 and `path_idle` is low, `maint_req` and `maint_urgent` stay low and no command is issued.
- R8: The backlog saturates at 3. At 3 with refresh enabled, `maint_urgent` and `maint_req` are high even while the path is busy, and no command is issued until `path_idle` rises. The burst then issues exactly 3 auto-refreshes, however many expiries occurred.
- R9: A pulse on `init_set` makes `init_busy` and `maint_req` rise in the next cycle. Nothing is issued while `path_idle` is low. Once the path is idle, the sequence is precharge-all, 3 auto-refreshes, then one mode-register load.
- R10: The cycle after the mode-register load, `init_busy` is low and `init_done` is high. A new `init_set` clears `init_done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_en | input | 1 | Enables the period timer and the servicing of owed refreshes |
| period | input | 12 | Refresh interval in clock cycles |
| trp_gap | input | 4 | Extra cycles after a precharge-all before the next command |
| trc_gap | input | 4 | Extra cycles after an auto-refresh before the next command |
| init_set | input | 1 | One-cycle pulse that requests the power-up sequence |
| path_idle | input | 1 | High when no memory access is in flight |
| maint_req | output | 1 | Asks the arbiter to hold off new accesses |
| maint_urgent | output | 1 | Backlog saturated; the refresh burst takes the next slot |
| cmd_dcab | output | 1 | Precharge-all-banks command strobe |
| cmd_refr | output | 1 | Auto-refresh command strobe |
| cmd_mrs | output | 1 | Mode-register-set command strobe |
| page_inval | output | 1 | Pulse that invalidates the controller's open-page record |
| init_busy | output | 1 | Initialization requested and not yet finished |
| init_done | output | 1 | Sticky flag set by the mode-register load |

## Verification
The bench builds the block with its default widths: a 12-bit period, 4-bit gaps and a 2-bit backlog. It programs a short period of 50 cycles for the periodic and saturation tests, and a period of 1000 cycles to stop expiries while a burst is counted. With a 50-cycle period, five expiries accumulate behind a busy path within a few hundred cycles. That checks saturation at 3 and the preempting request. Gap settings of 1/3 and 0/0 cover both the spaced and the back-to-back command timing.

// File: rtl/sdram_maint_pkg.sv
package sdram_maint_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DCAB = 2'd1,
        ST_REFR = 2'd2,
        ST_MRS  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic dcab;
        logic refr;
        logic mrs;
    } maint_cmd_t;

    localparam int INIT_REFR_DEFAULT = 3;

    function automatic logic cmd_any(input maint_cmd_t c);
        return c.dcab | c.refr | c.mrs;
    endfunction

endpackage

// File: rtl/maint_period_timer.sv
module maint_period_timer #(
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                refresh_en,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] limit;

    // A period of 0 behaves as 1 (tick every cycle)
    assign limit = (period == '0) ? '0 : period - 1'b1;
    assign tick  = refresh_en && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !refresh_en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/maint_backlog.sv
module maint_backlog #(
    parameter int BACKLOG_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inc,
    input  logic                 dec,
    output logic                 nonzero,
    output logic                 full
);
    localparam logic [BACKLOG_W-1:0] MAXV = '1;

    logic [BACKLOG_W-1:0] owed;

    assign nonzero = (owed != '0);
    assign full    = (owed == MAXV);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= MAXV;
        end else if (inc && !dec) begin
            if (owed != MAXV) owed <= owed + 1'b1;
        end else if (dec && !inc) begin
            if (owed != '0) owed <= owed - 1'b1;
        end else if (inc && dec && owed == '0) begin
            owed <= {{(BACKLOG_W-1){1'b0}}, 1'b1};
        end
    end

    // R8: an expiry at the ceiling leaves the count at the ceiling
    p_backlog_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (full && inc && !dec) |=> full);

    // R3: a refresh with nothing owed cannot wrap the count
    p_backlog_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (!nonzero && dec && !inc) |=> !nonzero);
endmodule

// File: rtl/maint_fsm.sv
module maint_fsm
    import sdram_maint_pkg::*;
#(
    parameter int GAP_W     = 4,
    parameter int INIT_REFR = INIT_REFR_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             refresh_en,
    input  logic             path_idle,
    input  logic             init_set,
    input  logic             backlog_nz,
    input  logic [GAP_W-1:0] trp_gap,
    input  logic [GAP_W-1:0] trc_gap,
    output maint_cmd_t       cmd,
    output logic             seq_idle,
    output logic             init_pend,
    output logic             init_done
);
    localparam int RL_W = $clog2(INIT_REFR + 1);

    seq_state_e       st, st_n;
    logic [GAP_W-1:0] wcnt, wcnt_n;
    logic             init_mode, init_mode_n;
    logic [RL_W-1:0]  refr_left, refr_left_n;
    logic             gap_open;

    assign gap_open = (wcnt == '0);
    assign seq_idle = (st == ST_IDLE);

    always_comb begin
        st_n        = st;
        wcnt_n      = wcnt;
        init_mode_n = init_mode;
        refr_left_n = refr_left;
        cmd         = '0;
        if (!gap_open) begin
            wcnt_n = wcnt - 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (path_idle && init_pend) begin
                        st_n        = ST_DCAB;
                        init_mode_n = 1'b1;
                        refr_left_n = RL_W'(INIT_REFR);
                    end else if (path_idle && refresh_en && backlog_nz) begin
                        st_n        = ST_DCAB;
                        init_mode_n = 1'b0;
                    end
                end
                ST_DCAB: begin
                    cmd.dcab = 1'b1;
                    wcnt_n   = trp_gap;
                    st_n     = ST_REFR;
                end
                ST_REFR: begin
                    if (init_mode) begin
                        cmd.refr    = 1'b1;
                        wcnt_n      = trc_gap;
                        refr_left_n = refr_left - 1'b1;
                        if (refr_left == RL_W'(1)) st_n = ST_MRS;
                    end else if (refresh_en && backlog_nz) begin
                        cmd.refr = 1'b1;
                        wcnt_n   = trc_gap;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end
                ST_MRS: begin
                    cmd.mrs     = 1'b1;
                    init_mode_n = 1'b0;
                    st_n        = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            wcnt      <= '0;
            init_mode <= 1'b0;
            refr_left <= '0;
        end else begin
            st        <= st_n;
            wcnt      <= wcnt_n;
            init_mode <= init_mode_n;
            refr_left <= refr_left_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_pend <= 1'b0;
            init_done <= 1'b0;
        end else if (cmd.mrs) begin
            init_pend <= 1'b0;
            init_done <= 1'b1;
        end else if (init_set && !init_pend) begin
            init_pend <= 1'b1;
            init_done <= 1'b0;
        end
    end

    // R4: command strobes never overlap
    p_onehot_cmd_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.dcab, cmd.refr, cmd.mrs}));

    // R6: a nonzero precharge gap leaves the next cycle empty
    p_trp_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.dcab && trp_gap != '0) |=> !cmd_any(cmd));

    // R6: a nonzero refresh gap leaves the next cycle empty
    p_trc_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.refr && trc_gap != '0) |=> !cmd_any(cmd));

    // R9: no sequence leaves idle while an access is in flight
    p_wait_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && !path_idle) |=> seq_idle);

    // R10: mode-register load finishes the initialization
    p_mrs_done_r10: assert property (@(posedge clk) disable iff (rst)
        cmd.mrs |=> (!init_pend && init_done));
endmodule

// File: rtl/sdram_maint_seq.sv
module sdram_maint_seq
    import sdram_maint_pkg::*;
#(
    parameter int PERIOD_W  = 12,
    parameter int GAP_W     = 4,
    parameter int BACKLOG_W = 2,
    parameter int INIT_REFR = INIT_REFR_DEFAULT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                refresh_en,
    input  logic [PERIOD_W-1:0] period,
    input  logic [GAP_W-1:0]    trp_gap,
    input  logic [GAP_W-1:0]    trc_gap,
    input  logic                init_set,
    input  logic                path_idle,
    output logic                maint_req,
    output logic                maint_urgent,
    output logic                cmd_dcab,
    output logic                cmd_refr,
    output logic                cmd_mrs,
    output logic                page_inval,
    output logic                init_busy,
    output logic                init_done
);
    logic       tick;
    logic       owed_nz;
    logic       owed_full;
    logic       seq_idle;
    logic       init_pend;
    maint_cmd_t cmd;

    maint_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .refresh_en (refresh_en),
        .period     (period),
        .tick       (tick)
    );

    maint_backlog #(.BACKLOG_W(BACKLOG_W)) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .dec     (cmd.refr),
        .nonzero (owed_nz),
        .full    (owed_full)
    );

    maint_fsm #(.GAP_W(GAP_W), .INIT_REFR(INIT_REFR)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .refresh_en (refresh_en),
        .path_idle  (path_idle),
        .init_set   (init_set),
        .backlog_nz (owed_nz),
        .trp_gap    (trp_gap),
        .trc_gap    (trc_gap),
        .cmd        (cmd),
        .seq_idle   (seq_idle),
        .init_pend  (init_pend),
        .init_done  (init_done)
    );

    assign maint_urgent = refresh_en && owed_full;
    assign maint_req    = !seq_idle || init_pend || maint_urgent
                        || (refresh_en && owed_nz && path_idle);
    assign cmd_dcab     = cmd.dcab;
    assign cmd_refr     = cmd.refr;
    assign cmd_mrs      = cmd.mrs;
    assign page_inval   = cmd.dcab;
    assign init_busy    = init_pend;

    // R8: a saturated backlog always holds the arbiter off
    p_urgent_req_r8: assert property (@(posedge clk) disable iff (rst)
        (maint_urgent && !path_idle) |=> maint_req);
endmodule

// File: tb/sim_sdram_maint_seq.sv
module sim_sdram_maint_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        refresh_en;
    logic [11:0] period;
    logic [3:0]  trp_gap;
    logic [3:0]  trc_gap;
    logic        init_set;
    logic        path_idle;
    logic        maint_req, maint_urgent, cmd_dcab, cmd_refr, cmd_mrs;
    logic        page_inval, init_busy, init_done;

    int  nchk = 0;
    int  nerr = 0;
    int  cyc  = 0;
    int  ev_n = 0;
    int  ev_cyc [64];
    byte ev_code[64];
    int  bad_onehot = 0;
    int  bad_inval  = 0;

    always #2 clk = ~clk;

    sdram_maint_seq u0 (
        .clk(clk), .rst(rst), .refresh_en(refresh_en), .period(period),
        .trp_gap(trp_gap), .trc_gap(trc_gap), .init_set(init_set),
        .path_idle(path_idle), .maint_req(maint_req), .maint_urgent(maint_urgent),
        .cmd_dcab(cmd_dcab), .cmd_refr(cmd_refr), .cmd_mrs(cmd_mrs),
        .page_inval(page_inval), .init_busy(init_busy), .init_done(init_done)
    );

    // Event log, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if ((32'(cmd_dcab) + 32'(cmd_refr) + 32'(cmd_mrs)) > 1) bad_onehot <= bad_onehot + 1;
        if (page_inval !== cmd_dcab) bad_inval <= bad_inval + 1;
        if (!rst && (cmd_dcab || cmd_refr || cmd_mrs) && ev_n < 64) begin
            ev_cyc[ev_n]  <= cyc;
            ev_code[ev_n] <= cmd_dcab ? "D" : (cmd_refr ? "R" : "M");
            ev_n          <= ev_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_log();
        @(negedge clk);
        ev_n = 0;
    endtask

    task automatic check_seq(input string exp, input string req);
        bit ok;
        ok = (ev_n == exp.len());
        for (int i = 0; i < ev_n && ok; i++) if (ev_code[i] != exp[i]) ok = 0;
        chk(ok, req, ev_n, exp.len());
    endtask

    task automatic check_gaps(input int first_gap, input int rest_gap, input string req);
        for (int i = 1; i < ev_n; i++) begin
            int e;
            e = (ev_code[i-1] == "D") ? first_gap : rest_gap;
            chk(ev_cyc[i] - ev_cyc[i-1] == e, req, ev_cyc[i] - ev_cyc[i-1], e);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; refresh_en = 1'b0; period = 12'd1000; trp_gap = 4'd1;
        trc_gap = 4'd3; init_set = 1'b0; path_idle = 1'b1;
        run(3);
        chk({cmd_dcab, cmd_refr, cmd_mrs, page_inval} == 4'b0, "R1 cmds", 32'({cmd_dcab, cmd_refr, cmd_mrs, page_inval}), 0);
        chk({init_busy, init_done, maint_req, maint_urgent} == 4'b0, "R1 flags", 32'({init_busy, init_done, maint_req, maint_urgent}), 0);
        rst = 1'b0;
    endtask

    task automatic t_disabled();
        clr_log();
        run(200);
        chk(ev_n == 0, "R2 no commands", ev_n, 0);
        chk(maint_req == 1'b0 && maint_urgent == 1'b0, "R2 no request", 32'({maint_req, maint_urgent}), 0);
    endtask

    task automatic t_power_drain();
        clr_log();
        refresh_en = 1'b1;
        #1;
        chk(maint_urgent == 1'b1, "R8 urgent at reset backlog", 32'(maint_urgent), 1);
        run(40);
        check_seq("DRRR", "R3 reset drain");
        check_gaps(2, 4, "R6 gaps 1/3");
        chk(maint_req == 1'b0 && maint_urgent == 1'b0, "R3 drained", 32'({maint_req, maint_urgent}), 0);
    endtask

    task automatic t_periodic();
        int nr;
        period = 12'd50;
        clr_log();
        run(170);
        nr = 0;
        for (int i = 0; i < ev_n; i++) begin
            byte e;
            e = (i % 2 == 0) ? "D" : "R";
            chk(ev_code[i] == e, "R5 burst pattern", 32'(ev_code[i]), 32'(e));
            if (ev_code[i] == "R") nr++;
            if (i >= 3 && i % 2 == 1)
                chk(ev_cyc[i] - ev_cyc[i-2] == 50, "R5 refresh spacing", ev_cyc[i] - ev_cyc[i-2], 50);
        end
        chk(nr >= 3, "R5 refresh count", nr, 3);
    endtask

    task automatic t_busy_saturate();
        int guard;
        guard = 0;
        while (!cmd_refr && guard < 200) begin run(1); guard++; end
        run(6);
        path_idle = 1'b0;
        clr_log();
        run(30);
        chk(maint_req == 1'b0, "R7 no request backlog 0", 32'(maint_req), 0);
        run(50);
        chk(maint_req == 1'b0 && maint_urgent == 1'b0, "R7 no request backlog 1", 32'({maint_req, maint_urgent}), 0);
        run(170);
        chk(maint_req == 1'b1, "R8 request when saturated", 32'(maint_req), 1);
        chk(maint_urgent == 1'b1, "R8 urgent when saturated", 32'(maint_urgent), 1);
        period = 12'd1000;
        run(10);
        chk(ev_n == 0, "R7 R8 nothing issued while busy", ev_n, 0);
        path_idle = 1'b1;
        run(40);
        check_seq("DRRR", "R8 saturated drain");
    endtask

    task automatic t_init_wait();
        int guard;
        path_idle = 1'b0;
        init_set  = 1'b1;
        run(1);
        init_set  = 1'b0;
        chk(init_busy == 1'b1 && maint_req == 1'b1, "R9 busy and request", 32'({init_busy, maint_req}), 3);
        clr_log();
        run(30);
        chk(ev_n == 0, "R9 wait for idle path", ev_n, 0);
        path_idle = 1'b1;
        guard = 0;
        while (!cmd_mrs && guard < 100) begin run(1); guard++; end
        run(1);
        chk(init_busy == 1'b0, "R10 busy cleared", 32'(init_busy), 0);
        chk(init_done == 1'b1, "R10 done raised", 32'(init_done), 1);
        run(20);
        check_seq("DRRRM", "R9 init sequence");
        check_gaps(2, 4, "R6 init gaps");
    endtask

    task automatic t_zero_gaps();
        trp_gap  = 4'd0;
        trc_gap  = 4'd0;
        clr_log();
        init_set = 1'b1;
        run(1);
        init_set = 1'b0;
        chk(init_done == 1'b0, "R10 done cleared by new request", 32'(init_done), 0);
        run(20);
        check_seq("DRRRM", "R9 init sequence zero gaps");
        check_gaps(1, 1, "R6 zero gaps");
        chk(bad_onehot == 0, "R4 one-hot commands", bad_onehot, 0);
        chk(bad_inval == 0, "R4 page invalidate with precharge", bad_inval, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled();
        t_power_drain();
        t_periodic();
        t_busy_saturate();
        t_init_wait();
        t_zero_gaps();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule